// File: doc/BRIEF.md
# Command Parity Checker with Stretched Error Flag

This block checks the parity of a command/address word on every clock edge. The included command bits and an accompanying parity bit are captured together. A registered parity result is produced, and any mismatch is reported on an active-low error flag. The flag is held low for a minimum number of cycles after a single error. When errors arrive back to back, the flag stays low for the whole run and then for the hold time.

Two active-low chip selects control a low-power mode. On a capture edge where both chip selects are high, that capture is ignored: the parity result is held and the captured word is not checked. One cycle later, a registered low-power flag freezes the error flag and its hold counter. Side-band bits, such as clock-enable and termination controls, are registered alongside the command but are kept out of the parity. An asynchronous active-low reset clears everything at once, and it takes priority over low power. Its release is synchronised to the clock.

Top module: `par_err_chk`

## Requirements
- R1: While `rst_n` is low, `err_n` is 1, `par_out` is 0 and `side_out` is 0, without waiting for a clock edge. After `rst_n` rises, the first two clock edges still leave all outputs at these values, and the third edge is the first capture.
- R2: On each capture edge that is not gated, `par_out` takes the XOR of all `cmd_in` bits and `par_in`. The parity is even, so a value of 1 means a mismatch.
- R3: A single mismatch captured on edge k drives `err_n` low after edge k+1, and `err_n` stays low for exactly MIN_HOLD (2) cycles before returning high.
- R4: N mismatches captured on consecutive ungated edges hold `err_n` low for N+MIN_HOLD-1 cycles without a break. A clean capture between two mismatches does not end the low period, as long as the hold has not run out.
- R5: `side_in` and the chip selects never enter the parity result. `side_out` is `side_in` registered on every edge, whether or not the edge is gated.
- R6: On a capture edge where `cs_a_n` and `cs_b_n` are both 1, `par_out` keeps its value and the word captured on that edge is never flagged.
- R7: After a capture edge with both chip selects at 1, the following edge leaves `err_n` and its remaining hold time unchanged.
- R8: When only one of the two chip selects is 1, capture, checking and `err_n` behave exactly as when both are 0.
- R9: Pulling `rst_n` low while low power is active and `err_n` is low forces `err_n` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_in | input | CMD_W | Command/address bits covered by parity |
| par_in | input | 1 | Even-parity bit sent with `cmd_in` |
| cs_a_n | input | 1 | First active-low chip select |
| cs_b_n | input | 1 | Second active-low chip select |
| side_in | input | SIDE_W | Side-band controls, excluded from parity |
| err_n | output | 1 | Active-low parity error flag, stretched |
| par_out | output | 1 | Registered parity result, 1 on mismatch |
| side_out | output | SIDE_W | Registered side-band controls |

## Verification
The bench targets the edges of the hold window. These are a lone error, runs of two and three errors, and a clean capture placed inside an open hold. A counter that reloaded wrongly or decremented one cycle early would release `err_n` too soon, or leave it low one cycle too long. Low power is entered both while `err_n` is low and while it is high, and mismatching words are fed during the gated cycles. A design that gated with the wrong delay, or that checked gated words, would then move `err_n` or `par_out`. The bench also asserts reset in the middle of a frozen error. A design that let low power override reset would keep `err_n` low.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  // Result of one capture edge, handed from the capture stage to the latch.
  typedef struct packed {
    logic mismatch;  // XOR of included bits and parity bit (1 = error)
    logic lowpow;    // both chip selects were high at this capture
  } chk_stage_t;

  localparam int unsigned DEF_CMD_W    = 22;
  localparam int unsigned DEF_SIDE_W   = 2;
  localparam int unsigned DEF_MIN_HOLD = 2;
  localparam int unsigned DEF_SYNC     = 2;

endpackage

// File: rtl/pchk_rst_sync.sv
module pchk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pchk_capture.sv
module pchk_capture
  import pchk_pkg::*;
#(
  parameter int unsigned CMD_W  = DEF_CMD_W,
  parameter int unsigned SIDE_W = DEF_SIDE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              par_in,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic [SIDE_W-1:0] side_in,
  output chk_stage_t        stage_q,
  output logic [SIDE_W-1:0] side_q
);

  logic       lp_now;
  logic       cap_en;
  chk_stage_t stage_d;

  // Low power when neither chip select is asserted.
  always_comb begin
    lp_now           = cs_a_n & cs_b_n;
    cap_en           = ~lp_now;
    stage_d.lowpow   = lp_now;
    stage_d.mismatch = stage_q.mismatch;
    if (cap_en) stage_d.mismatch = (^cmd_in) ^ par_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      side_q  <= '0;
    end else begin
      stage_q <= stage_d;
      side_q  <= side_in;
    end
  end

endmodule

// File: rtl/pchk_err_latch.sv
module pchk_err_latch
  import pchk_pkg::*;
#(
  parameter int unsigned MIN_HOLD = DEF_MIN_HOLD,
  localparam int unsigned HOLD_W  = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mismatch,
  input  logic              freeze,
  output logic              err_n,
  output logic [HOLD_W-1:0] hold_left
);

  localparam logic [HOLD_W-1:0] RELOAD = HOLD_W'(MIN_HOLD - 1);

  logic              err_n_d;
  logic [HOLD_W-1:0] hold_d;
  logic              upd_en;

  always_comb begin
    upd_en  = ~freeze;
    err_n_d = err_n;
    hold_d  = hold_left;
    if (upd_en) begin
      if (mismatch) begin
        err_n_d = 1'b0;
        hold_d  = RELOAD;
      end else if (hold_left != '0) begin
        err_n_d = 1'b0;
        hold_d  = hold_left - 1'b1;
      end else begin
        err_n_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_n     <= 1'b1;
      hold_left <= '0;
    end else begin
      err_n     <= err_n_d;
      hold_left <= hold_d;
    end
  end

endmodule

// File: rtl/par_err_chk.sv
module par_err_chk
  import pchk_pkg::*;
#(
  parameter int unsigned CMD_W    = DEF_CMD_W,
  parameter int unsigned SIDE_W   = DEF_SIDE_W,
  parameter int unsigned MIN_HOLD = DEF_MIN_HOLD,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              par_in,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic [SIDE_W-1:0] side_in,
  output logic              err_n,
  output logic              par_out,
  output logic [SIDE_W-1:0] side_out
);

  localparam int unsigned HOLD_W = (MIN_HOLD > 2) ? $clog2(MIN_HOLD) : 1;

  logic              rst_sync_n;
  chk_stage_t        stage_q;
  logic              mism_q;
  logic              lps_q;
  logic [HOLD_W-1:0] hold_left;
  logic              hold_busy;

  pchk_rst_sync #(.STAGES(SYNC)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  pchk_capture #(.CMD_W(CMD_W), .SIDE_W(SIDE_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_in  (cmd_in),
    .par_in  (par_in),
    .cs_a_n  (cs_a_n),
    .cs_b_n  (cs_b_n),
    .side_in (side_in),
    .stage_q (stage_q),
    .side_q  (side_out)
  );

  assign mism_q    = stage_q.mismatch;
  assign lps_q     = stage_q.lowpow;
  assign par_out   = mism_q;
  assign hold_busy = |hold_left;

  pchk_err_latch #(.MIN_HOLD(MIN_HOLD)) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mismatch  (mism_q),
    .freeze    (lps_q),
    .err_n     (err_n),
    .hold_left (hold_left)
  );

endmodule

// File: rtl/pchk_checker.sv
module pchk_checker #(
  parameter int unsigned SIDE_W = 2
) (
  input logic              clk,
  input logic              srst_n,
  input logic              cs_a_n,
  input logic              cs_b_n,
  input logic [SIDE_W-1:0] side_in,
  input logic [SIDE_W-1:0] side_out,
  input logic              par_out,
  input logic              err_n,
  input logic              mismatch,
  input logic              lps,
  input logic              hold_busy
);

  // R3: once the flag falls it is still low on the next cycle
  assert_min_hold_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(err_n) |=> !err_n);

  // R3: with no pending error, no hold left and no freeze, the flag releases
  assert_release_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!err_n && !hold_busy && !mismatch && !lps) |=> err_n);

  // R4: a pending mismatch that is not frozen drives the flag low
  assert_err_follows_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (mismatch && !lps) |=> !err_n);

  // R5: side-band bits are a one-cycle copy of the input
  assert_side_copy_R5: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> (side_out == $past(side_in)));

  // R6: a gated capture leaves the parity result alone
  assert_par_hold_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (cs_a_n && cs_b_n) |=> $stable(par_out));

  // R7: the registered low-power flag freezes the error flag
  assert_err_frozen_R7: assert property (@(posedge clk) disable iff (!srst_n)
    lps |=> $stable(err_n));

endmodule

bind par_err_chk pchk_checker #(.SIDE_W(SIDE_W)) u_chk (
  .clk       (clk),
  .srst_n    (rst_sync_n),
  .cs_a_n    (cs_a_n),
  .cs_b_n    (cs_b_n),
  .side_in   (side_in),
  .side_out  (side_out),
  .par_out   (par_out),
  .err_n     (err_n),
  .mismatch  (mism_q),
  .lps       (lps_q),
  .hold_busy (hold_busy)
);

// File: tb/par_err_chk_bench.sv
`timescale 1ns/1ps
module par_err_chk_bench;

  localparam int CMD_W  = 22;
  localparam int SIDE_W = 2;
  localparam int HOLD   = 2;
  localparam int SYNC   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CMD_W-1:0]  cmd_in;
  logic              par_in;
  logic              cs_a_n, cs_b_n;
  logic [SIDE_W-1:0] side_in;
  logic              err_n, par_out;
  logic [SIDE_W-1:0] side_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  bit              m_err_n, m_par, m_lps;
  int              m_cnt, m_skip;
  bit [SIDE_W-1:0] m_side;

  always #4 clk = ~clk;

  par_err_chk u_par_err_chk (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .par_in(par_in),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .side_in(side_in),
    .err_n(err_n), .par_out(par_out), .side_out(side_out)
  );

  task automatic model_reset();
    m_err_n = 1; m_par = 0; m_lps = 0; m_cnt = 0; m_side = '0;
  endtask

  task automatic model_edge(input bit [CMD_W-1:0] c, input bit p,
                            input bit a, input bit b, input bit [SIDE_W-1:0] s);
    if (m_skip > 0) begin
      m_skip--;
    end else begin
      if (!m_lps) begin
        if (m_par) begin
          m_err_n = 0; m_cnt = HOLD - 1;
        end else if (m_cnt > 0) begin
          m_cnt--; m_err_n = 0;
        end else begin
          m_err_n = 1;
        end
      end
      m_lps = a & b;
      if (!(a & b)) m_par = (^c) ^ p;
      m_side = s;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "err_n", int'(err_n), int'(m_err_n));
    chk(tag, "par_out", int'(par_out), int'(m_par));
    chk(tag, "side_out", int'(side_out), int'(m_side));
  endtask

  task automatic cycle(input bit [CMD_W-1:0] c, input bit p, input bit a,
                       input bit b, input bit [SIDE_W-1:0] s, input string tag);
    cmd_in = c; par_in = p; cs_a_n = a; cs_b_n = b; side_in = s;
    @(posedge clk);
    model_edge(c, p, a, b, s);
    @(negedge clk);
    compare(tag);
  endtask

  // send a random word; err=1 makes the parity mismatch
  task automatic send(input bit err, input bit a, input bit b, input string tag);
    bit [CMD_W-1:0] c = CMD_W'($urandom);
    cycle(c, (^c) ^ err, a, b, SIDE_W'($urandom), tag);
  endtask

  task automatic hit_reset(input string tag);
    rst_n = 1'b0;
    #1;
    model_reset();
    compare(tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    rst_n = 1'b1;
    m_skip = SYNC;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_in = '0; par_in = 0; cs_a_n = 0; cs_b_n = 0; side_in = '0;
    m_skip = 0;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    m_skip = SYNC;
    // R1: two edges after release still show reset values
    for (int i = 0; i < SYNC; i++) cycle('1, 1'b0, 0, 0, '1, "R1");
    // R2: clean and single-bit-wrong words, parity output
    for (int i = 0; i < 8; i++) send(0, 0, 0, "R2");
    cycle(22'h000001, 1'b0, 0, 0, '0, "R2");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R2");
    // R3: lone error
    send(1, 0, 0, "R3");
    for (int i = 0; i < 5; i++) send(0, 0, 0, "R3");
    // R4: runs of two and three, and a gap inside the hold
    send(1, 0, 0, "R4"); send(1, 0, 0, "R4");
    for (int i = 0; i < 5; i++) send(0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) send(1, 0, 0, "R4");
    for (int i = 0; i < 5; i++) send(0, 0, 0, "R4");
    send(1, 0, 0, "R4"); send(0, 0, 0, "R4"); send(1, 0, 0, "R4");
    for (int i = 0; i < 5; i++) send(0, 0, 0, "R4");
    // R5: side bits and chip selects vary, parity clean
    cycle('0, 1'b0, 0, 1, 2'b11, "R5");
    cycle('0, 1'b0, 1, 0, 2'b01, "R5");
    cycle('0, 1'b0, 1, 1, 2'b10, "R5");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R5");
    // R8: one chip select high still checks
    send(1, 0, 1, "R8");
    for (int i = 0; i < 4; i++) send(0, 1, 0, "R8");
    // R6/R7: freeze an active error, mismatching words while gated
    send(1, 0, 0, "R7");
    send(0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) send(1, 1, 1, "R7");
    for (int i = 0; i < 5; i++) send(0, 0, 0, "R7");
    // R6: gated mismatches while flag high are never flagged
    for (int i = 0; i < 4; i++) send(1, 1, 1, "R6");
    for (int i = 0; i < 4; i++) send(0, 0, 0, "R6");
    // R9: reset during frozen error
    send(1, 0, 0, "R9");
    send(1, 1, 1, "R9");
    send(1, 1, 1, "R9");
    hit_reset("R9");
    for (int i = 0; i < SYNC + 3; i++) send(0, 0, 0, "R1");
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      send(r < 3, r == 9, r >= 8, "R4");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule